// File: doc/BRIEF.md
# PCI Type-0 Configuration Header Register File

This block keeps the configuration header of a 32-bit PCI target that sits behind a fixed bus-protocol core. The core passes configuration accesses in as requests that carry a dword register index. Writes bring 32-bit data with active-low byte-lane enables, and reads return the addressed dword on a response channel. Some header fields drive other logic all the time. The I/O-enable and memory-enable command bits and the decoded BAR bases go to the address decoder. The parity-response and SERR-enable command bits go back to the protocol core. The core reports parity errors and signalled system errors as one-cycle pulses, and the block holds them in the status register until software clears them.

Identification values, the two BAR types and sizes, and the size and place of the capability window are parameters. A request moves on a valid/ready handshake. A write is complete when it is accepted and produces no response. An accepted read produces exactly one response one cycle later. This response sits in a one-entry register, so `req_ready` is low whenever a response is waiting and `rsp_ready` is low. A stalled response keeps its data unchanged until it is taken.

Top module: `cfgspace_regfile`

## Requirements
- R1: After reset the command register is 0, so `io_en`, `mem_en`, `perr_resp_en` and `serr_en` are 0. Both error status bits are 0, `rsp_valid` is 0, and index 1 reads 32'h0010_0000.
- R2: Index 0 reads {DEVICE_ID, VENDOR_ID} and index 2 reads CLASS_REV. Writes to these indices change nothing.
- R3: In the dword at index 1, only command bits 0 (I/O enable), 1 (memory enable), 6 (parity response) and 8 (SERR enable) can be written. The other command bits read 0. The four bits drive `io_en`, `mem_en`, `perr_resp_en` and `serr_en` in the cycle after the write.
- R4: A write updates byte lane k (data bits 8k+7..8k) only when `req_be_n[k]` is 0. This applies to the command, BAR and capability storage, and to the lane 3 clear bits.
- R5: An `evt_perr` pulse sets dword bit 31 (status bit 15) of index 1. An `evt_serr` pulse sets dword bit 30 (status bit 14). Both bits stay set.
- R6: Writing 1 to dword bit 31 or bit 30 with lane 3 enabled clears that bit, and writing 0 leaves it unchanged. When a set pulse and a clearing write arrive in the same cycle, the bit stays set.
- R7: BAR0 at index 4 is memory space of 2^BAR0_SZ_LOG2 bytes and reads bit 0 as 0. BAR1 at index 5 is I/O space of 2^BAR1_SZ_LOG2 bytes and reads bit 0 as 1. Bits below the size read 0, so with the default sizes all-ones reads 32'hFFFF_F000 and 32'hFFFF_FF01. `bar_value` carries the same values.
- R8: Index 13 reads the capability pointer CAP_BASE_IDX*4 (32'h40 by default), and dword bit 20 of index 1 reads 1. Indices CAP_BASE_IDX to CAP_BASE_IDX+CAP_DEPTH-1 are read/write storage that reset to 0.
- R9: Any other index, such as 3, 20 or 255, reads 0, and a write to it has no effect.
- R10: `req_ready` is low exactly while `rsp_valid` is 1 and `rsp_ready` is 0. A stalled response keeps `rsp_rdata` stable. Each accepted read gives one response, and writes give none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request valid |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_index | input | IDX_W | Dword register index |
| req_wdata | input | 32 | Write data |
| req_be_n | input | 4 | Active-low byte-lane enables |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_rdata | output | 32 | Read data |
| evt_perr | input | 1 | One-cycle parity-error-detected pulse |
| evt_serr | input | 1 | One-cycle system-error-signalled pulse |
| io_en | output | 1 | Command bit 0 |
| mem_en | output | 1 | Command bit 1 |
| perr_resp_en | output | 1 | Command bit 6 |
| serr_en | output | 1 | Command bit 8 |
| bar_value | output | NUM_BARS*32 | BAR values as read, BAR0 in the low dword |

## Verification
The hardest case to reach from the ports is an error pulse and a write-one-to-clear of the same status bit landing on the same clock edge. To get there, the bench drives `evt_perr` and the clearing write from one step at the same falling edge, so both are seen on the next rising edge. It then reads the status back and expects the bit still set. A second hard case is a response stalled behind a low `rsp_ready` while a second read waits. The bench holds `rsp_ready` low across several edges and checks that `req_ready` is low and the first response does not change. It then releases the stall and checks that both responses arrive in order.

// File: rtl/cfgspace_pkg.sv
package cfgspace_pkg;
  localparam int DW    = 32;
  localparam int LANES = DW / 8;

  // Replace each byte lane whose active-low enable is 0.
  function automatic logic [DW-1:0] merge_lanes(input logic [DW-1:0] cur,
                                                input logic [DW-1:0] nxt,
                                                input logic [LANES-1:0] be_n);
    logic [DW-1:0] r;
    for (int k = 0; k < LANES; k++)
      r[k*8 +: 8] = be_n[k] ? cur[k*8 +: 8] : nxt[k*8 +: 8];
    return r;
  endfunction
endpackage

// File: rtl/cfgspace_cmd_stat.sv
module cfgspace_cmd_stat
  import cfgspace_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [DW-1:0]    wdata,
  input  logic [LANES-1:0] be_n,
  input  logic             evt_perr,
  input  logic             evt_serr,
  output logic [15:0]      cmd,
  output logic             stat_perr,
  output logic             stat_serr
);
  localparam logic [15:0] CMD_WMASK = 16'h0143;

  logic [DW-1:0] merged;
  logic          clr_perr, clr_serr;

  assign merged   = merge_lanes({16'h0, cmd}, wdata, be_n);
  assign clr_perr = wr_en && !be_n[3] && wdata[31];
  assign clr_serr = wr_en && !be_n[3] && wdata[30];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd       <= '0;
      stat_perr <= 1'b0;
      stat_serr <= 1'b0;
    end else begin
      if (wr_en) cmd <= merged[15:0] & CMD_WMASK;
      // a set pulse outranks a clear in the same cycle
      if (evt_perr)      stat_perr <= 1'b1;
      else if (clr_perr) stat_perr <= 1'b0;
      if (evt_serr)      stat_serr <= 1'b1;
      else if (clr_serr) stat_serr <= 1'b0;
    end
  end
endmodule

// File: rtl/cfgspace_bar.sv
module cfgspace_bar
  import cfgspace_pkg::*;
#(
  parameter bit IS_IO   = 1'b0,
  parameter int SZ_LOG2 = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [DW-1:0]    wdata,
  input  logic [LANES-1:0] be_n,
  output logic [DW-1:0]    value
);
  localparam logic [DW-1:0] ADDR_MASK = ~((DW'(1) << SZ_LOG2) - DW'(1));
  localparam logic [DW-1:0] TYPE_BITS = IS_IO ? DW'(1) : DW'(0);

  logic [DW-1:0] base_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     base_q <= '0;
    else if (wr_en) base_q <= merge_lanes(base_q, wdata, be_n) & ADDR_MASK;
  end

  assign value = base_q | TYPE_BITS;
endmodule

// File: rtl/cfgspace_ext.sv
module cfgspace_ext
  import cfgspace_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int SW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SW-1:0]    slot,
  input  logic [DW-1:0]    wdata,
  input  logic [LANES-1:0] be_n,
  output logic [DW-1:0]    rdata
);
  logic [DW-1:0] mem [DEPTH];

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         mem[gi] <= '0;
      else if (wr_en && slot == SW'(gi))  mem[gi] <= merge_lanes(mem[gi], wdata, be_n);
    end
  end

  assign rdata = (32'(slot) < DEPTH) ? mem[slot] : '0;
endmodule

// File: rtl/cfgspace_regfile.sv
module cfgspace_regfile
  import cfgspace_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID    = 16'hABCD,
  parameter logic [15:0] DEVICE_ID    = 16'h0123,
  parameter logic [31:0] CLASS_REV    = 32'h0580_0001,
  parameter int          NUM_BARS     = 2,
  parameter bit          BAR0_IS_IO   = 1'b0,
  parameter int          BAR0_SZ_LOG2 = 12,
  parameter bit          BAR1_IS_IO   = 1'b1,
  parameter int          BAR1_SZ_LOG2 = 8,
  parameter int          CAP_BASE_IDX = 16,
  parameter int          CAP_DEPTH    = 4,
  parameter int          IDX_W        = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic                   req_write,
  input  logic [IDX_W-1:0]       req_index,
  input  logic [31:0]            req_wdata,
  input  logic [3:0]             req_be_n,
  output logic                   rsp_valid,
  input  logic                   rsp_ready,
  output logic [31:0]            rsp_rdata,
  input  logic                   evt_perr,
  input  logic                   evt_serr,
  output logic                   io_en,
  output logic                   mem_en,
  output logic                   perr_resp_en,
  output logic                   serr_en,
  output logic [NUM_BARS*32-1:0] bar_value
);
  localparam int          IDX_ID    = 0;
  localparam int          IDX_CMD   = 1;
  localparam int          IDX_CLASS = 2;
  localparam int          IDX_BAR0  = 4;
  localparam int          IDX_CAPP  = 13;
  localparam int          SW        = (CAP_DEPTH > 1) ? $clog2(CAP_DEPTH) : 1;
  localparam logic [31:0] CAP_PTR   = 32'(CAP_BASE_IDX * 4);
  localparam bit          HAS_CAP   = (CAP_DEPTH > 0);

  logic              fire, wr_fire;
  logic [15:0]       cmd;
  logic              stat_perr, stat_serr;
  logic [31:0]       bar_q [2];
  logic              in_ext;
  logic [IDX_W-1:0]  ext_off;
  logic [31:0]       ext_rdata;
  logic [31:0]       rd_mux;

  assign req_ready = !rsp_valid || rsp_ready;
  assign fire      = req_valid && req_ready;
  assign wr_fire   = fire && req_write;

  cfgspace_cmd_stat u_cmd (
    .clk, .rst_n,
    .wr_en     (wr_fire && req_index == IDX_W'(IDX_CMD)),
    .wdata     (req_wdata),
    .be_n      (req_be_n),
    .evt_perr, .evt_serr,
    .cmd, .stat_perr, .stat_serr
  );

  assign io_en        = cmd[0];
  assign mem_en       = cmd[1];
  assign perr_resp_en = cmd[6];
  assign serr_en      = cmd[8];

  for (genvar gi = 0; gi < 2; gi++) begin : g_bar
    if (gi < NUM_BARS) begin : g_on
      cfgspace_bar #(
        .IS_IO   (gi == 0 ? BAR0_IS_IO : BAR1_IS_IO),
        .SZ_LOG2 (gi == 0 ? BAR0_SZ_LOG2 : BAR1_SZ_LOG2)
      ) u_bar (
        .clk, .rst_n,
        .wr_en (wr_fire && req_index == IDX_W'(IDX_BAR0 + gi)),
        .wdata (req_wdata),
        .be_n  (req_be_n),
        .value (bar_q[gi])
      );
      assign bar_value[gi*32 +: 32] = bar_q[gi];
    end else begin : g_off
      assign bar_q[gi] = '0;
    end
  end

  assign ext_off = req_index - IDX_W'(CAP_BASE_IDX);
  assign in_ext  = (32'(req_index) >= CAP_BASE_IDX) &&
                   (32'(req_index) <  CAP_BASE_IDX + CAP_DEPTH);

  cfgspace_ext #(.DEPTH(CAP_DEPTH)) u_ext (
    .clk, .rst_n,
    .wr_en (wr_fire && in_ext),
    .slot  (ext_off[SW-1:0]),
    .wdata (req_wdata),
    .be_n  (req_be_n),
    .rdata (ext_rdata)
  );

  always_comb begin
    rd_mux = '0;
    if (in_ext) rd_mux = ext_rdata;
    else begin
      case (32'(req_index))
        IDX_ID:       rd_mux = {DEVICE_ID, VENDOR_ID};
        IDX_CMD:      rd_mux = {stat_perr, stat_serr, 9'b0, HAS_CAP, 4'b0, cmd};
        IDX_CLASS:    rd_mux = CLASS_REV;
        IDX_BAR0:     rd_mux = bar_q[0];
        IDX_BAR0 + 1: rd_mux = bar_q[1];
        IDX_CAPP:     rd_mux = HAS_CAP ? CAP_PTR : '0;
        default:      rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (fire && !req_write) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= rd_mux;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/cfgspace_regfile_chk.sv
module cfgspace_regfile_chk #(
  parameter bit BAR0_IS_IO   = 1'b0,
  parameter int BAR0_SZ_LOG2 = 12,
  parameter int NUM_BARS     = 2,
  parameter int IDX_W        = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   req_valid,
  input logic                   req_ready,
  input logic                   req_write,
  input logic [IDX_W-1:0]       req_index,
  input logic [31:0]            req_wdata,
  input logic [3:0]             req_be_n,
  input logic                   rsp_valid,
  input logic                   rsp_ready,
  input logic [31:0]            rsp_rdata,
  input logic                   evt_perr,
  input logic                   io_en,
  input logic                   mem_en,
  input logic                   stat_perr,
  input logic [NUM_BARS*32-1:0] bar_value
);
  logic cmd_wr, cmd_lane0_seen;
  assign cmd_wr = req_valid && req_ready && req_write && req_index == IDX_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        cmd_lane0_seen <= 1'b0;
    else if (cmd_wr && !req_be_n[0])   cmd_lane0_seen <= 1'b1;
  end

  assert_cmd_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_lane0_seen |-> (!mem_en && !io_en));

  assert_mem_en_by_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_en) |-> $past(cmd_wr && !req_be_n[0] && req_wdata[1]));

  assert_perr_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    evt_perr |=> stat_perr);

  assert_perr_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stat_perr) |-> $past(cmd_wr && !req_be_n[3] && req_wdata[31] && !evt_perr));

  assert_bar0_lowbits_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bar_value[BAR0_SZ_LOG2-1:1] == '0) && (bar_value[0] == BAR0_IS_IO));

  assert_stall_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);

  assert_rsp_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));
endmodule

bind cfgspace_regfile cfgspace_regfile_chk #(
  .BAR0_IS_IO(BAR0_IS_IO), .BAR0_SZ_LOG2(BAR0_SZ_LOG2),
  .NUM_BARS(NUM_BARS), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .req_index(req_index), .req_wdata(req_wdata),
  .req_be_n(req_be_n), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
  .rsp_rdata(rsp_rdata), .evt_perr(evt_perr), .io_en(io_en), .mem_en(mem_en),
  .stat_perr(stat_perr), .bar_value(bar_value)
);

// File: tb/sim_cfgspace_regfile.sv
module sim_cfgspace_regfile;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [7:0]  req_index = '0;
  logic [31:0] req_wdata = '0;
  logic [3:0]  req_be_n = 4'hF;
  logic        rsp_ready = 1'b1;
  logic        evt_perr = 1'b0, evt_serr = 1'b0;
  logic        req_ready, rsp_valid, io_en, mem_en, perr_resp_en, serr_en;
  logic [31:0] rsp_rdata;
  logic [63:0] bar_value;

  int checks = 0, fails = 0;
  logic [31:0] exp_q [$];
  string       tag_q [$];

  always #10 clk = ~clk;

  cfgspace_regfile u0 (.*);

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pop on every response handshake
  always @(negedge clk) begin
    if (rst_n && rsp_valid && rsp_ready) begin
      if (exp_q.size() == 0) check(1'b0, "R10 unexpected response", rsp_rdata, 32'h0);
      else begin
        automatic logic [31:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(rsp_rdata === e, t, rsp_rdata, e);
      end
    end
  end

  task automatic issue(input bit wr, input logic [7:0] idx, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_index = idx; req_wdata = d; req_be_n = be;
    while (!req_ready) @(negedge clk);
    @(posedge clk); #1;
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic wr(input logic [7:0] idx, input logic [31:0] d, input logic [3:0] be);
    issue(1'b1, idx, d, be);
  endtask

  task automatic rd(input logic [7:0] idx, input logic [31:0] e, input string tag);
    exp_q.push_back(e); tag_q.push_back(tag);
    issue(1'b0, idx, 32'h0, 4'hF);
  endtask

  task automatic pulse(input bit p, input bit s);
    @(negedge clk); evt_perr = p; evt_serr = s;
    @(posedge clk); #1; evt_perr = 1'b0; evt_serr = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog", 32'h0, 32'h0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check({io_en, mem_en, perr_resp_en, serr_en, rsp_valid} == 5'b0, "R1 reset outputs",
          {27'h0, io_en, mem_en, perr_resp_en, serr_en, rsp_valid}, 32'h0);
    rd(8'd1, 32'h0010_0000, "R1 cmd/status reset");
    // R2 identity, write ignored
    rd(8'd0, 32'h0123_ABCD, "R2 id");
    wr(8'd0, 32'hFFFF_FFFF, 4'h0);
    rd(8'd0, 32'h0123_ABCD, "R2 id after write");
    rd(8'd2, 32'h0580_0001, "R2 class");
    // R3 command bits
    wr(8'd1, 32'h0000_FFFF, 4'h0);
    @(negedge clk);
    check({io_en, mem_en, perr_resp_en, serr_en} == 4'hF, "R3 command outputs set",
          {28'h0, io_en, mem_en, perr_resp_en, serr_en}, 32'hF);
    rd(8'd1, 32'h0010_0143, "R3 command readback");
    // R4 lane 0 only clears bits 0,1,6
    wr(8'd1, 32'h0, 4'b1110);
    @(negedge clk);
    check(!mem_en && !io_en && !perr_resp_en && serr_en, "R4 lane0 only",
          {28'h0, io_en, mem_en, perr_resp_en, serr_en}, 32'h1);
    wr(8'd1, 32'h0, 4'b1101);
    rd(8'd1, 32'h0010_0000, "R4 lane1 clears serr_en");
    // R5 error events
    pulse(1'b1, 1'b0);
    rd(8'd1, 32'h8010_0000, "R5 perr set");
    pulse(1'b0, 1'b1);
    rd(8'd1, 32'hC010_0000, "R5 serr set, perr sticky");
    // R6 write-one-to-clear
    wr(8'd1, 32'h4000_0000, 4'b0111);
    rd(8'd1, 32'h8010_0000, "R6 serr cleared only");
    wr(8'd1, 32'hC000_0000, 4'b1111);
    rd(8'd1, 32'h8010_0000, "R4 lane3 disabled no clear");
    wr(8'd1, 32'h0, 4'b0000);
    rd(8'd1, 32'h8010_0000, "R6 write zero keeps");
    fork
      wr(8'd1, 32'h8000_0000, 4'b0111);
      pulse(1'b1, 1'b0);
    join
    rd(8'd1, 32'h8010_0000, "R6 set wins over clear");
    wr(8'd1, 32'h8000_0000, 4'b0111);
    rd(8'd1, 32'h0010_0000, "R6 perr cleared");
    // R7 BARs
    rd(8'd4, 32'h0000_0000, "R7 mem BAR reset");
    rd(8'd5, 32'h0000_0001, "R7 io BAR reset");
    wr(8'd4, 32'hFFFF_FFFF, 4'h0);
    wr(8'd5, 32'hFFFF_FFFF, 4'h0);
    rd(8'd4, 32'hFFFF_F000, "R7 mem BAR size mask");
    rd(8'd5, 32'hFFFF_FF01, "R7 io BAR size mask");
    @(negedge clk);
    check(bar_value == 64'hFFFF_FF01_FFFF_F000, "R7 bar_value port", bar_value[31:0], 32'hFFFF_F000);
    wr(8'd4, 32'h1234_5678, 4'b0011);
    rd(8'd4, 32'h1234_F000, "R4 BAR upper lanes only");
    // R8 capability pointer and window
    rd(8'd13, 32'h0000_0040, "R8 cap pointer");
    rd(8'd17, 32'h0, "R8 window reset");
    wr(8'd16, 32'hDEAD_BEEF, 4'h0);
    wr(8'd19, 32'h1122_3344, 4'b1010);
    rd(8'd16, 32'hDEAD_BEEF, "R8 window slot0");
    rd(8'd19, 32'h0022_0044, "R8 window slot3 lanes");
    // R9 unimplemented
    wr(8'd3, 32'hFFFF_FFFF, 4'h0);
    wr(8'd20, 32'hFFFF_FFFF, 4'h0);
    rd(8'd3, 32'h0, "R9 idx3");
    rd(8'd20, 32'h0, "R9 idx20");
    rd(8'd255, 32'h0, "R9 idx255");
    rd(8'd16, 32'hDEAD_BEEF, "R9 window untouched");
    // R10 stalled response
    @(posedge clk); #1 rsp_ready = 1'b0;
    rd(8'd0, 32'h0123_ABCD, "R10 first stalled response");
    @(negedge clk);
    check(rsp_valid && !req_ready && rsp_rdata == 32'h0123_ABCD, "R10 stall holds",
          rsp_rdata, 32'h0123_ABCD);
    repeat (2) @(negedge clk);
    check(rsp_valid && !req_ready && rsp_rdata == 32'h0123_ABCD, "R10 stall stable",
          rsp_rdata, 32'h0123_ABCD);
    fork
      rd(8'd2, 32'h0580_0001, "R10 second response after stall");
      begin repeat (2) @(posedge clk); #1 rsp_ready = 1'b1; end
    join
    repeat (4) @(negedge clk);
    check(exp_q.size() == 0 && !rsp_valid, "R10 one response per read",
          32'(exp_q.size()), 32'h0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule